// File: doc/BRIEF.md
# SPI EEPROM Command and Status Controller

This block is the slave-side control logic of a serial nonvolatile memory reached over SPI. It watches chip select, serial clock and serial data in, oversampled by the block's own system clock, collects an opcode and its payload, and decides at the moment chip select returns high whether the frame was a valid command. It keeps an 8-bit status byte: a ready/busy flag, a write-enable latch, two block-protect bits and a status-lock bit. The protect bits and the lock bit are held in ordinary flops in place of nonvolatile cells. The memory array itself is not part of this block. An accepted data-write or status-write launches a self-timed busy period of a programmable number of clocks. When that period ends, the write-enable latch clears.

The frame tracker moves through five states. `F_IDLE` goes to `F_OPCODE` when chip select falls. `F_OPCODE` moves on the eighth SCK rising edge, to `F_READ` for the status-read opcode, to `F_PAYLOAD` for the status-write and data-write opcodes, and to `F_TAIL` for anything else. Every state returns to `F_IDLE` when chip select rises, and a frame-complete pulse is raised at that point. The command controller has two states. `C_READY` goes to `C_BUSY` when a frame is accepted as a write. `C_BUSY` returns to `C_READY` after the programmed number of clocks.

Top module: `eep_cmd_status_ctrl`

## Requirements
- R1: Serial input is sampled on SCK rising edges while chip select is low, MSB first. SCK may idle low (mode 0) or high (mode 3) when chip select falls, and both behave the same.
- R2: The status byte has RDY at bit 0, WEN at bit 1, BP0 at bit 2, BP1 at bit 3 and LOCK at bit 7, and reads 0 at bits 4 to 6. Opcode 05h returns it MSB first on SO, with each bit changing on an SCK falling edge after the opcode. The byte repeats for as long as clocking continues.
- R3: SO is high-impedance whenever chip select is high.
- R4: Opcode 06h in a frame of exactly 8 clocks sets WEN, and opcode 04h in exactly 8 clocks clears it.
- R5: Opcode 01h in exactly 16 clocks with WEN=1 loads data bits 2, 3 and 7 into BP0, BP1 and LOCK when chip select rises and starts a busy period. Data bits 0, 1 and 4 to 6 are ignored.
- R6: A status-write is rejected, with WEN unchanged and no busy period, when the write-protect pin is low and LOCK is 1.
- R7: A frame whose clock count does not fit its opcode changes nothing, and WEN keeps its value.
- R8: Opcode 02h followed by a 2-byte address (the low 13 bits are used) and between 1 and PAGE_BYTES data bytes, with WEN=1, starts a busy period when the address is unprotected. Protection is set by BP1:BP0: 00 protects nothing, 01 protects 1800h and above, 10 protects 1000h and above, and 11 protects everything.
- R9: A data-write to a protected address is rejected, and WEN keeps its value.
- R10: RDY is 1 for exactly BUSY_CYCLES clocks after an accepted write. WEN is 0 once RDY falls.
- R11: While RDY is 1, every command except status-read is ignored.
- R12: After reset the status byte is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out, high-impedance while not reading |

## Verification
The embedded properties check on every cycle several rules that hold whatever the command history. The output enable drops after chip select rises. The bit counter clears outside a frame. Every rise of RDY follows a frame completion. Every busy period lasts exactly the programmed length and ends with WEN clear. Frames arriving during busy leave the protect bits untouched, and locked status-writes leave the status unchanged. Only the bench's scenarios can show how the clock count, write enable, protect map and pin level combine into accept or reject decisions for concrete frames. The same holds for mode 3 framing and for the serial byte actually seen on SO. The bench compares each of these against its own transaction model.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_DATA_WR = 8'h02;
    localparam logic [7:0] OP_WR_DIS  = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_WR_EN   = 8'h06;

    typedef enum logic [2:0] {
        F_IDLE,
        F_OPCODE,
        F_PAYLOAD,
        F_READ,
        F_TAIL
    } frame_state_t;

    typedef enum logic {
        C_READY,
        C_BUSY
    } ctrl_state_t;

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic cs_n_s,
    output logic si_s,
    output logic wp_n_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    // bit order in each stage: {wp_n, si, sck, cs_n}
    localparam logic [3:0] RST_VAL = 4'b1001;

    logic [3:0] pipe [STAGES];
    logic       sck_prev;
    logic       cs_prev;

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[k] <= RST_VAL;
                    else        pipe[k] <= {wp_n, si, sck, cs_n};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[k] <= RST_VAL;
                    else        pipe[k] <= pipe[k-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= pipe[STAGES-1][1];
            cs_prev  <= pipe[STAGES-1][0];
        end
    end

    assign cs_n_s   = pipe[STAGES-1][0];
    assign si_s     = pipe[STAGES-1][2];
    assign wp_n_s   = pipe[STAGES-1][3];
    assign sck_rise = pipe[STAGES-1][1] & ~sck_prev;
    assign sck_fall = ~pipe[STAGES-1][1] & sck_prev;
    assign cs_rise  = pipe[STAGES-1][0] & ~cs_prev;

endmodule

// File: rtl/eep_spi_frontend.sv
module eep_spi_frontend
    import eep_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_s,
    input  logic             si_s,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             cs_rise,
    input  logic [7:0]       status_byte,
    output logic             frame_done,
    output logic [7:0]       opcode,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [7:0]       byte1,
    output logic [7:0]       byte2,
    output logic             so_q,
    output logic             so_oe
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    frame_state_t st, nxt;
    logic [7:0]   shreg;
    logic [7:0]   op_now;
    logic [6:0]   oshift;
    logic [2:0]   rd_idx;
    logic         rise_act;
    logic         fall_act;

    assign op_now   = {shreg[6:0], si_s};
    assign rise_act = sck_rise & ~cs_n_s;
    assign fall_act = sck_fall & ~cs_n_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= F_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            F_IDLE: if (!cs_n_s) nxt = F_OPCODE;
            F_OPCODE: begin
                if (cs_n_s) nxt = F_IDLE;
                else if (rise_act && bit_cnt == CNT_W'(7)) begin
                    if (op_now == OP_STAT_RD)
                        nxt = F_READ;
                    else if (op_now == OP_STAT_WR || op_now == OP_DATA_WR)
                        nxt = F_PAYLOAD;
                    else
                        nxt = F_TAIL;
                end
            end
            F_PAYLOAD, F_READ, F_TAIL: if (cs_n_s) nxt = F_IDLE;
            default: nxt = F_IDLE;
        endcase
    end

    assign frame_done = cs_rise & (st != F_IDLE);

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            opcode  <= '0;
            byte1   <= '0;
            byte2   <= '0;
            oshift  <= '0;
            rd_idx  <= '0;
            so_q    <= 1'b0;
            so_oe   <= 1'b0;
        end else if (cs_n_s) begin
            shreg   <= '0;
            bit_cnt <= '0;
            opcode  <= '0;
            rd_idx  <= '0;
            so_oe   <= 1'b0;
        end else begin
            if (rise_act) begin
                shreg <= op_now;
                if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + CNT_W'(1);
                if (bit_cnt == CNT_W'(7)) opcode <= op_now;
                if (st == F_PAYLOAD && bit_cnt[2:0] == 3'd7) begin
                    if ((bit_cnt >> 3) == CNT_W'(1))      byte1 <= op_now;
                    else if ((bit_cnt >> 3) == CNT_W'(2)) byte2 <= op_now;
                end
            end
            if (fall_act && st == F_READ) begin
                so_oe  <= 1'b1;
                rd_idx <= rd_idx + 3'd1;
                if (rd_idx == 3'd0) begin
                    so_q   <= status_byte[7];
                    oshift <= status_byte[6:0];
                end else begin
                    so_q   <= oshift[6];
                    oshift <= {oshift[5:0], 1'b0};
                end
            end
        end
    end

    // R3: output driver released one cycle after chip select is seen high
    p_so_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !so_oe);

    // R7: no clock count survives from one frame into the next
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> (bit_cnt == '0));

    // R2: output enable only ever rises during a status-read frame
    p_oe_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> ($past(st) == F_READ));

endmodule

// File: rtl/eep_status_ctrl.sv
module eep_status_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_BYTES  = 32,
    parameter int BUSY_CYCLES = 250000,
    parameter int CNT_W       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic [7:0]       opcode,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic [7:0]       byte1,
    input  logic [7:0]       byte2,
    input  logic             wp_n_s,
    output logic [7:0]       status_byte
);
    localparam int TMR_W     = $clog2(BUSY_CYCLES + 1);
    localparam int MAX_WR    = 24 + 8 * PAGE_BYTES;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(BUSY_CYCLES - 1);

    ctrl_state_t st, nxt;
    logic [TMR_W-1:0] timer;
    logic             wen;
    logic [1:0]       bp;
    logic             lock;
    logic [15:0]      addr_full;
    logic [ADDR_W-1:0] addr;
    logic             addr_prot;
    logic             len_ok;
    logic             acc_stat;
    logic             acc_data;
    logic             start_busy;
    logic             busy_end;
    logic             unused_hi;

    assign addr_full = {byte1, byte2};
    assign addr      = addr_full[ADDR_W-1:0];
    assign unused_hi = ^addr_full;

    always_comb begin
        unique case (bp)
            2'b00: addr_prot = 1'b0;
            2'b01: addr_prot = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
            2'b10: addr_prot = addr[ADDR_W-1];
            default: addr_prot = 1'b1;
        endcase
    end

    assign len_ok   = (bit_cnt >= CNT_W'(32)) && (bit_cnt[2:0] == 3'd0)
                      && (bit_cnt <= CNT_W'(MAX_WR));
    assign acc_stat = (st == C_READY) && frame_done && (opcode == OP_STAT_WR)
                      && (bit_cnt == CNT_W'(16)) && wen && !(!wp_n_s && lock);
    assign acc_data = (st == C_READY) && frame_done && (opcode == OP_DATA_WR)
                      && len_ok && wen && !addr_prot;
    assign start_busy = acc_stat | acc_data;
    assign busy_end   = (st == C_BUSY) && (timer == TMR_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= C_READY;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            C_READY: if (start_busy) nxt = C_BUSY;
            C_BUSY:  if (busy_end)   nxt = C_READY;
            default: nxt = C_READY;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
            wen   <= 1'b0;
            bp    <= 2'b00;
            lock  <= 1'b0;
        end else begin
            unique case (st)
                C_READY: begin
                    timer <= '0;
                    if (frame_done && bit_cnt == CNT_W'(8)) begin
                        if (opcode == OP_WR_EN)  wen <= 1'b1;
                        if (opcode == OP_WR_DIS) wen <= 1'b0;
                    end
                    if (acc_stat) begin
                        bp   <= byte1[3:2];
                        lock <= byte1[7];
                    end
                end
                C_BUSY: begin
                    timer <= timer + TMR_W'(1);
                    if (busy_end) wen <= 1'b0;
                end
                default: timer <= '0;
            endcase
        end
    end

    assign status_byte = {lock, 3'b000, bp, wen, (st == C_BUSY)};

    // R5/R8: busy only begins right after a completed frame
    p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[0]) |-> $past(frame_done));

    // R10: busy length is exactly the programmed count
    p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_byte[0]) |-> ($past(timer) == TMR_LAST));

    // R10: the enable latch is clear once busy ends
    p_wen_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_byte[0]) |-> !status_byte[1]);

    // R11: frames arriving during busy leave protection untouched
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[0] && frame_done) |=> $stable(status_byte[7:2]));

    // R6: locked status-write with pin low changes nothing
    p_wp_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !status_byte[0] && opcode == OP_STAT_WR && !wp_n_s
         && status_byte[7]) |=> ($stable(status_byte) ));

endmodule

// File: rtl/eep_cmd_status_ctrl.sv
module eep_cmd_status_ctrl #(
    parameter int ADDR_W      = 13,
    parameter int PAGE_BYTES  = 32,
    parameter int BUSY_CYCLES = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic so
);
    localparam int MAX_BITS = 24 + 8 * PAGE_BYTES;
    localparam int CNT_W    = $clog2(MAX_BITS + 2);

    logic             cs_n_s, si_s, wp_n_s;
    logic             sck_rise, sck_fall, cs_rise;
    logic             frame_done;
    logic [7:0]       opcode, byte1, byte2, status_byte;
    logic [CNT_W-1:0] bit_cnt;
    logic             so_q, so_oe;

    eep_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .si       (si),
        .wp_n     (wp_n),
        .cs_n_s   (cs_n_s),
        .si_s     (si_s),
        .wp_n_s   (wp_n_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    eep_spi_frontend #(.CNT_W(CNT_W)) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_s      (cs_n_s),
        .si_s        (si_s),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .cs_rise     (cs_rise),
        .status_byte (status_byte),
        .frame_done  (frame_done),
        .opcode      (opcode),
        .bit_cnt     (bit_cnt),
        .byte1       (byte1),
        .byte2       (byte2),
        .so_q        (so_q),
        .so_oe       (so_oe)
    );

    eep_status_ctrl #(
        .ADDR_W      (ADDR_W),
        .PAGE_BYTES  (PAGE_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .opcode      (opcode),
        .bit_cnt     (bit_cnt),
        .byte1       (byte1),
        .byte2       (byte2),
        .wp_n_s      (wp_n_s),
        .status_byte (status_byte)
    );

    assign so = so_oe ? so_q : 1'bz;

endmodule

// File: tb/eep_cmd_status_ctrl_test.sv
`timescale 1ns/1ps
module eep_cmd_status_ctrl_test;
    localparam int BUSY = 1500;
    localparam int PAGE = 32;
    localparam int HALF = 6;

    logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, wp_n = 1;
    wire  so;

    int checks = 0, errors = 0, zviol = 0, cs_hi_cnt = 0;
    bit done = 0;

    logic [7:0] txb [0:40];
    logic [7:0] rx_first, rx_second;

    // behavioural model state
    bit       m_wen = 0, m_busy = 0, m_lock = 0;
    bit [1:0] m_bp  = 0;

    eep_cmd_status_ctrl #(.ADDR_W(13), .PAGE_BYTES(PAGE), .BUSY_CYCLES(BUSY),
                          .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .wp_n(wp_n), .so(so));

    always #4 clk = ~clk;

    // R3: compared on every clock against the pin-level model
    always @(negedge clk) begin
        if (cs_n) cs_hi_cnt = cs_hi_cnt + 1; else cs_hi_cnt = 0;
        if (rst_n && cs_hi_cnt > 5 && so !== 1'bz) zviol = zviol + 1;
    end

    function automatic logic [7:0] m_status();
        return {m_lock, 3'b000, m_bp, m_wen, m_busy};
    endfunction

    function automatic bit m_prot(int a);
        case (m_bp)
            2'd0: return 0;
            2'd1: return a >= 'h1800;
            2'd2: return a >= 'h1000;
            default: return 1;
        endcase
    endfunction

    // model update at chip-select rise
    task automatic model_frame(int nbits);
        int a;
        if (nbits < 8 || m_busy) return;
        case (txb[0])
            8'h06: if (nbits == 8) m_wen = 1;
            8'h04: if (nbits == 8) m_wen = 0;
            8'h01: if (nbits == 16 && m_wen && !(!wp_n && m_lock)) begin
                m_bp = txb[1][3:2]; m_lock = txb[1][7]; m_busy = 1;
            end
            8'h02: begin
                a = {txb[1], txb[2]} & 'h1FFF;
                if (nbits >= 32 && nbits % 8 == 0 && nbits <= 24 + 8*PAGE
                    && m_wen && !m_prot(a)) m_busy = 1;
            end
            default: ;
        endcase
    endtask

    task automatic frame(int nbits, bit mode3);
        rx_first = 0; rx_second = 0;
        @(negedge clk); sck = mode3;
        repeat (HALF) @(negedge clk);
        cs_n = 0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sck = 0; si = txb[i/8][7 - (i%8)];
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i < 16) rx_first  = {rx_first[6:0], so};
            if (i >= 16 && i < 24) rx_second = {rx_second[6:0], so};
            sck = 1;
            repeat (HALF) @(negedge clk);
        end
        if (!mode3) sck = 0;
        repeat (HALF) @(negedge clk);
        cs_n = 1;
        model_frame(nbits);
        repeat (HALF * 2) @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic read_status(string req, bit mode3);
        txb[0] = 8'h05; txb[1] = 0;
        frame(16, mode3);
        chk(req, rx_first, m_status());
    endtask

    task automatic cmd(logic [7:0] op, int nbits, bit mode3);
        txb[0] = op; frame(nbits, mode3);
    endtask

    task automatic settle();
        repeat (BUSY + 200) @(negedge clk);
        if (m_busy) begin m_busy = 0; m_wen = 0; end
    endtask

    task automatic data_write(int addr, int nbytes);
        txb[0] = 8'h02; txb[1] = addr[15:8]; txb[2] = addr[7:0];
        for (int i = 0; i < nbytes && i < 38; i++) txb[3+i] = 8'(i * 7);
        frame(24 + 8 * nbytes, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);

        read_status("R12 reset status", 0);
        cmd(8'h06, 8, 1);
        read_status("R1 R4 write enable in mode 3", 1);
        cmd(8'h04, 8, 0);
        read_status("R4 write disable", 0);
        cmd(8'h06, 9, 0);
        read_status("R7 enable with 9 clocks ignored", 0);
        cmd(8'h06, 8, 0);
        txb[0] = 8'h01; txb[1] = 8'hFF; frame(15, 0);
        read_status("R7 short status-write keeps enable", 0);

        txb[0] = 8'h01; txb[1] = 8'hFF; frame(16, 0);
        read_status("R5 R2 status-write accepted, busy shown", 0);
        cmd(8'h04, 8, 0);
        read_status("R11 disable ignored while busy", 1);
        settle();
        read_status("R10 enable cleared after busy", 0);

        cmd(8'h06, 8, 0);
        wp_n = 0;
        txb[0] = 8'h01; txb[1] = 8'h00; frame(16, 0);
        read_status("R6 locked status-write rejected", 0);
        wp_n = 1;
        txb[0] = 8'h01; txb[1] = 8'h74; frame(16, 0);
        settle();
        read_status("R5 only bits 2 3 7 written", 0);

        cmd(8'h06, 8, 0);
        data_write('h1900, 1);
        read_status("R9 protected address rejected", 0);
        data_write('h0100, 2);
        read_status("R8 data write starts busy", 0);
        settle();
        read_status("R10 busy over after data write", 0);

        cmd(8'h06, 8, 0);
        data_write('h0010, PAGE + 1);
        read_status("R8 over-page write rejected", 0);
        data_write('h0010, 0);
        read_status("R7 write without data rejected", 0);
        data_write('h1000, PAGE);
        read_status("R8 full page write accepted", 0);
        settle();

        txb[0] = 8'h05; txb[1] = 0; txb[2] = 0;
        frame(24, 1);
        chk("R2 repeated status byte first", rx_first, m_status());
        chk("R2 repeated status byte second", rx_second, m_status());

        checks++;
        if (zviol != 0) begin
            errors++;
            $display("FAIL R3: actual %0d driven cycles expected 0", zviol);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule